// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block sequences a five-instruction multicycle processor (load word, store word, register-register ALU, branch-on-equal and jump) as a microprogram instead of as a hand-drawn state machine. A micro-program counter selects one word of a ten-entry microcode store. Each word holds packed fields for ALU operation, ALU operand sources, register file action, memory action, PC update and next-address sequencing. Per-field decoders expand each packed field into the datapath control lines. The datapath, memory and ALU are outside this block. The only input from them is the 6-bit opcode from the instruction register.

Each instruction starts with two shared words. FETCH reads memory at PC into the instruction register and writes PC+4. DECODE computes the branch target and lets the register file load A and B. After DECODE, a first opcode-indexed table picks the class entry: MEM_ADDR, RTYPE_EXEC, BRANCH or JUMP. MEM_ADDR consults a second table that picks LOAD_READ or STORE_WRITE. The remaining transitions are LOAD_READ→LOAD_WB and RTYPE_EXEC→RTYPE_WB, both by increment. STORE_WRITE, LOAD_WB, RTYPE_WB, BRANCH and JUMP all return to FETCH. An opcode that a table does not list also returns to FETCH. A synchronous reset forces FETCH.

Top module: `mcu_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle presents the FETCH control word.
- R2: FETCH drives mem_rd=1, ir_wr=1, iord=0, pc_wr=1, pc_src=00, alu_src_a=0 (PC), alu_src_b=01 (constant 4) and alu_op=00 (add). The cycle after FETCH is always DECODE. DECODE drives alu_src_b=11 (shifted immediate), alu_src_a=0, alu_op=00, and no enable.
- R3: Sequencing code 11 advances the micro-PC by one: FETCH→DECODE, LOAD_READ→LOAD_WB and RTYPE_EXEC→RTYPE_WB. Code 00 returns to FETCH.
- R4: The first dispatch, taken after DECODE, maps opcode 0x23 and 0x2B to MEM_ADDR, 0x00 to RTYPE_EXEC, 0x04 to BRANCH and 0x02 to JUMP. Every other opcode goes back to FETCH.
- R5: MEM_ADDR drives alu_src_a=1 (A), alu_src_b=10 (unshifted immediate) and alu_op=00. The second dispatch uses the opcode present during MEM_ADDR: 0x23 goes to LOAD_READ, 0x2B goes to STORE_WRITE, and anything else goes to FETCH.
- R6: LOAD_READ drives mem_rd=1 and iord=1. LOAD_WB drives reg_wr=1, mem_to_reg=1 and reg_dst=0 (rt).
- R7: STORE_WRITE drives mem_wr=1 and iord=1, with mem_rd=0.
- R8: RTYPE_EXEC drives alu_op=10 (function code), alu_src_a=1 and alu_src_b=00 (B). RTYPE_WB drives reg_wr=1, reg_dst=1 (rd) and mem_to_reg=0.
- R9: BRANCH drives alu_op=01 (subtract), alu_src_a=1, alu_src_b=00, pc_wr_cond=1, pc_src=01 and pc_wr=0.
- R10: JUMP drives pc_wr=1 and pc_src=10.
- R11: A blank field drives its enables (mem_rd, mem_wr, ir_wr, reg_wr, pc_wr, pc_wr_cond) low and its selects (iord, reg_dst, mem_to_reg, pc_src) to zero. A word with no ALU action drives the ALU fields to zero.
- R12: mem_rd and mem_wr are never high together, and pc_wr and pc_wr_cond are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALUOut, 10 jump target |
| iord | output | 1 | Memory address: 0 PC, 1 ALUOut |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data: 0 ALUOut, 1 MDR |
| reg_dst | output | 1 | Register destination: 0 rt, 1 rd |
| reg_wr | output | 1 | Register file write |
| alu_src_a | output | 1 | ALU operand A: 0 PC, 1 A |
| alu_src_b | output | 2 | ALU operand B: 00 B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function code |

## Verification
The bench walks all 64 opcodes through a full instruction each and compares every cycle's control word against vectors built from the requirements. An unlisted opcode must come back to FETCH with no stray enable during DECODE. A table that sent it anywhere else would show a write strobe or a missing FETCH. A second test changes the opcode between the two dispatches, so a design that latched the second lookup from the first one would enter the wrong memory word. A reset raised in the middle of a load must land on FETCH at once, not after the write-back.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

    parameter int OPC_W  = 6;
    parameter int UPC_W  = 4;

    localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OP_JMP   = 6'h02;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

    typedef enum logic [UPC_W-1:0] {
        U_FETCH      = 4'd0,
        U_DECODE     = 4'd1,
        U_MEM_ADDR   = 4'd2,
        U_LOAD_READ  = 4'd3,
        U_LOAD_WB    = 4'd4,
        U_STORE_WR   = 4'd5,
        U_RTYPE_EXEC = 4'd6,
        U_RTYPE_WB   = 4'd7,
        U_BRANCH     = 4'd8,
        U_JUMP       = 4'd9
    } uaddr_t;

    // sequencing codes
    typedef enum logic [1:0] {
        SQ_FETCH = 2'b00,
        SQ_DISP1 = 2'b01,
        SQ_DISP2 = 2'b10,
        SQ_NEXT  = 2'b11
    } seq_t;

    // memory field codes
    localparam logic [1:0] MF_NONE  = 2'b00;
    localparam logic [1:0] MF_WRALU = 2'b01;
    localparam logic [1:0] MF_RDPC  = 2'b10;
    localparam logic [1:0] MF_RDALU = 2'b11;

    // register field codes (0x = no write)
    localparam logic [1:0] RF_NONE  = 2'b00;
    localparam logic [1:0] RF_WRALU = 2'b10;
    localparam logic [1:0] RF_WRMDR = 2'b11;

    // PC-update field codes
    localparam logic [1:0] PF_NONE = 2'b00;
    localparam logic [1:0] PF_ALU  = 2'b01;
    localparam logic [1:0] PF_COND = 2'b10;
    localparam logic [1:0] PF_JUMP = 2'b11;

    typedef struct packed {
        logic [1:0] alu_op;
        logic       src_a;
        logic [1:0] src_b;
        logic [1:0] reg_f;
        logic [1:0] mem_f;
        logic [1:0] pc_f;
        seq_t       seq;
    } uword_t;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic [1:0] pc_src;
        logic       iord;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       mem_to_reg;
        logic       reg_dst;
        logic       reg_wr;
        logic       alu_src_a;
        logic [1:0] alu_src_b;
        logic [1:0] alu_op;
    } ctrl_t;

endpackage

// File: rtl/mcu_ustore.sv
module mcu_ustore
    import mcu_pkg::*;
(
    input  uaddr_t upc,
    output uword_t word
);

    function automatic uword_t mk(
        input logic [1:0] op, input logic sa, input logic [1:0] sb,
        input logic [1:0] rf, input logic [1:0] mf, input logic [1:0] pf,
        input seq_t sq);
        uword_t w;
        w.alu_op = op;
        w.src_a  = sa;
        w.src_b  = sb;
        w.reg_f  = rf;
        w.mem_f  = mf;
        w.pc_f   = pf;
        w.seq    = sq;
        return w;
    endfunction

    always_comb begin
        unique case (upc)
            U_FETCH:      word = mk(2'b00, 1'b0, 2'b01, RF_NONE,  MF_RDPC,  PF_ALU,  SQ_NEXT);
            U_DECODE:     word = mk(2'b00, 1'b0, 2'b11, RF_NONE,  MF_NONE,  PF_NONE, SQ_DISP1);
            U_MEM_ADDR:   word = mk(2'b00, 1'b1, 2'b10, RF_NONE,  MF_NONE,  PF_NONE, SQ_DISP2);
            U_LOAD_READ:  word = mk(2'b00, 1'b0, 2'b00, RF_NONE,  MF_RDALU, PF_NONE, SQ_NEXT);
            U_LOAD_WB:    word = mk(2'b00, 1'b0, 2'b00, RF_WRMDR, MF_NONE,  PF_NONE, SQ_FETCH);
            U_STORE_WR:   word = mk(2'b00, 1'b0, 2'b00, RF_NONE,  MF_WRALU, PF_NONE, SQ_FETCH);
            U_RTYPE_EXEC: word = mk(2'b10, 1'b1, 2'b00, RF_NONE,  MF_NONE,  PF_NONE, SQ_NEXT);
            U_RTYPE_WB:   word = mk(2'b00, 1'b0, 2'b00, RF_WRALU, MF_NONE,  PF_NONE, SQ_FETCH);
            U_BRANCH:     word = mk(2'b01, 1'b1, 2'b00, RF_NONE,  MF_NONE,  PF_COND, SQ_FETCH);
            U_JUMP:       word = mk(2'b00, 1'b0, 2'b00, RF_NONE,  MF_NONE,  PF_JUMP, SQ_FETCH);
            default:      word = mk(2'b00, 1'b0, 2'b00, RF_NONE,  MF_NONE,  PF_NONE, SQ_FETCH);
        endcase
    end

endmodule

// File: rtl/mcu_dispatch.sv
module mcu_dispatch
    import mcu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output uaddr_t           tgt1,
    output uaddr_t           tgt2
);

    always_comb begin
        case (opcode)
            OP_LOAD, OP_STORE: tgt1 = U_MEM_ADDR;
            OP_RTYPE:          tgt1 = U_RTYPE_EXEC;
            OP_BEQ:            tgt1 = U_BRANCH;
            OP_JMP:            tgt1 = U_JUMP;
            default:           tgt1 = U_FETCH;
        endcase
    end

    always_comb begin
        case (opcode)
            OP_LOAD:  tgt2 = U_LOAD_READ;
            OP_STORE: tgt2 = U_STORE_WR;
            default:  tgt2 = U_FETCH;
        endcase
    end

endmodule

// File: rtl/mcu_fdec.sv
module mcu_fdec
    import mcu_pkg::*;
(
    input  uword_t word,
    output ctrl_t  ctl
);

    always_comb begin
        ctl = '0;
        ctl.alu_op    = word.alu_op;
        ctl.alu_src_a = word.src_a;
        ctl.alu_src_b = word.src_b;

        // register field: high bit enables write, low bit picks MDR
        if (word.reg_f[1]) begin
            ctl.reg_wr     = 1'b1;
            ctl.mem_to_reg = word.reg_f[0];
            ctl.reg_dst    = ~word.reg_f[0];
        end

        unique case (word.mem_f)
            MF_RDPC:  begin ctl.mem_rd = 1'b1; ctl.ir_wr = 1'b1; end
            MF_RDALU: begin ctl.mem_rd = 1'b1; ctl.iord  = 1'b1; end
            MF_WRALU: begin ctl.mem_wr = 1'b1; ctl.iord  = 1'b1; end
            default:  ;
        endcase

        unique case (word.pc_f)
            PF_ALU:  begin ctl.pc_wr = 1'b1;      ctl.pc_src = 2'b00; end
            PF_COND: begin ctl.pc_wr_cond = 1'b1; ctl.pc_src = 2'b01; end
            PF_JUMP: begin ctl.pc_wr = 1'b1;      ctl.pc_src = 2'b10; end
            default: ;
        endcase
    end

endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
    import mcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic [1:0]       pc_src,
    output logic             iord,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             mem_to_reg,
    output logic             reg_dst,
    output logic             reg_wr,
    output logic             alu_src_a,
    output logic [1:0]       alu_src_b,
    output logic [1:0]       alu_op
);

    uaddr_t upc, upc_nxt, tgt1, tgt2;
    uword_t word;
    ctrl_t  ctl;

    mcu_ustore   u_store (.upc(upc), .word(word));
    mcu_dispatch u_disp  (.opcode(opcode), .tgt1(tgt1), .tgt2(tgt2));
    mcu_fdec     u_fdec  (.word(word), .ctl(ctl));

    always_comb begin
        unique case (word.seq)
            SQ_NEXT:  upc_nxt = uaddr_t'(upc + 1'b1);
            SQ_DISP1: upc_nxt = tgt1;
            SQ_DISP2: upc_nxt = tgt2;
            default:  upc_nxt = U_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) upc <= U_FETCH;
        else     upc <= upc_nxt;
    end

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign pc_src     = ctl.pc_src;
    assign iord       = ctl.iord;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign mem_to_reg = ctl.mem_to_reg;
    assign reg_dst    = ctl.reg_dst;
    assign reg_wr     = ctl.reg_wr;
    assign alu_src_a  = ctl.alu_src_a;
    assign alu_src_b  = ctl.alu_src_b;
    assign alu_op     = ctl.alu_op;

    // R12
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R12
    pcw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pc_wr && pc_wr_cond));

    // R2
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (alu_src_b == 2'b11 && !ir_wr && !reg_wr && !mem_wr && !pc_wr));

    // R6
    load_read_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && iord) |=> (reg_wr && mem_to_reg && !reg_dst));

    // R3
    final_step_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || mem_wr || pc_wr_cond) |=> (ir_wr && mem_rd));

    // R10
    jump_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b10) |=> ir_wr);

endmodule

// File: tb/mcu_ctrl_tb.sv
module mcu_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr;
    logic       mem_to_reg, reg_dst, reg_wr, alu_src_a;
    logic [1:0] pc_src, alu_src_b, alu_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcu_ctrl u_dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
        .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .mem_to_reg(mem_to_reg), .reg_dst(reg_dst), .reg_wr(reg_wr),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op)
    );

    typedef enum int {K_FETCH, K_DEC, K_MADDR, K_LRD, K_LWB, K_SWR,
                      K_REX, K_RWB, K_BR, K_JMP} kind_t;

    // order: pc_wr,pc_wr_cond,pc_src,iord,mem_rd,mem_wr,ir_wr,
    //        mem_to_reg,reg_dst,reg_wr,alu_src_a,alu_src_b,alu_op
    function automatic logic [15:0] expv(input kind_t k);
        logic [15:0] v;
        v = '0;
        case (k)
            K_FETCH: v = {1'b1,1'b0,2'b00,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00};
            K_DEC:   v = {1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00};
            K_MADDR: v = {1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00};
            K_LRD:   v = {1'b0,1'b0,2'b00,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00};
            K_LWB:   v = {1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00};
            K_SWR:   v = {1'b0,1'b0,2'b00,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00};
            K_REX:   v = {1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10};
            K_RWB:   v = {1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00};
            K_BR:    v = {1'b0,1'b1,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b01};
            K_JMP:   v = {1'b1,1'b0,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00};
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string tag, input kind_t k);
        logic [15:0] act, exp;
        act = {pc_wr, pc_wr_cond, pc_src, iord, mem_rd, mem_wr, ir_wr,
               mem_to_reg, reg_dst, reg_wr, alu_src_a, alu_src_b, alu_op};
        exp = expv(k);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s opcode=%h step=%s actual=%b expected=%b",
                     tag, opcode, k.name(), act, exp);
        end
    endtask

    // one full instruction; entered at a falling edge while in FETCH
    task automatic run_instr(input logic [5:0] op);
        opcode = op;
        check("R2", K_FETCH);
        @(negedge clk); check("R3", K_DEC);   // R3 increment, R11 blank fields
        @(negedge clk);
        case (op)
            6'h23: begin
                check("R4", K_MADDR);
                @(negedge clk); check("R5", K_LRD);   // R6 read
                @(negedge clk); check("R6", K_LWB);   // R3 increment
                @(negedge clk); check("R3", K_FETCH); // R3 return
            end
            6'h2B: begin
                check("R4", K_MADDR);
                @(negedge clk); check("R7", K_SWR);
                @(negedge clk); check("R3", K_FETCH);
            end
            6'h00: begin
                check("R4", K_REX);
                @(negedge clk); check("R8", K_RWB);
                @(negedge clk); check("R3", K_FETCH);
            end
            6'h04: begin
                check("R9", K_BR);
                @(negedge clk); check("R3", K_FETCH);
            end
            6'h02: begin
                check("R10", K_JMP);
                @(negedge clk); check("R3", K_FETCH);
            end
            default: check("R4", K_FETCH);  // unlisted: back to fetch
        endcase
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", K_FETCH);
        rst = 1'b0;

        // exhaustive opcode sweep, R4 R11
        for (int i = 0; i < 64; i++) run_instr(6'(i));

        // R5: second table uses opcode present in MEM_ADDR (load -> store)
        opcode = 6'h23;
        check("R2", K_FETCH);
        @(negedge clk); check("R2", K_DEC);
        @(negedge clk); check("R5", K_MADDR);
        opcode = 6'h2B;
        @(negedge clk); check("R5", K_SWR);
        @(negedge clk); check("R5", K_FETCH);

        // R5: non-memory opcode at second dispatch -> fetch
        opcode = 6'h23;
        @(negedge clk); check("R2", K_DEC);
        @(negedge clk); check("R5", K_MADDR);
        opcode = 6'h00;
        @(negedge clk); check("R5", K_FETCH);

        // R1: reset mid load
        opcode = 6'h23;
        @(negedge clk); check("R2", K_DEC);
        @(negedge clk); check("R5", K_MADDR);
        rst = 1'b1;
        @(negedge clk); check("R1", K_FETCH);
        rst = 1'b0;
        @(negedge clk); check("R1", K_DEC);
        @(negedge clk); check("R5", K_MADDR);
        @(negedge clk); check("R6", K_LRD);
        @(negedge clk); check("R6", K_LWB);
        @(negedge clk); check("R3", K_FETCH);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule